// File: doc/BRIEF.md
# Chained-Buffer DMA Channel Register File

This block holds the software-visible state of a receive channel and a transmit channel that serve one serial peripheral. Each channel keeps an active buffer, described by a memory address and a remaining-move count, and a queued buffer described the same way. Software programs both buffers through a small register window on a peripheral bus. A separate sequencer moves the data and pulses a per-channel completion input after every move. On each pulse the block advances the active address by the element size and counts down the remaining moves.

When the active count runs out, the block raises the channel's end flag. If a queued buffer is waiting, the block promotes it to active in the same clock and zeroes the queued count, so the next transfer starts with no software intervention. A drained flag is high while both counts of a channel are zero: it means buffer-full on the receive side and buffer-empty on the transmit side. A write-only control word turns each direction on or off, and a read-only status word reports both enable states. The block requests a move for a channel only when that channel is enabled, the peripheral is ready and the count is not zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every pointer and counter reads zero, both enables are off, both end flags are low, both drained flags are high and no request is raised.
- R2: Register offsets are 0x100 receive address, 0x104 receive count, 0x108 transmit address, 0x10C transmit count, 0x110 queued receive address, 0x114 queued receive count, 0x118 queued transmit address, 0x11C queued transmit count, 0x120 control (write-only, reads zero) and 0x124 status (read-only). Any other offset reads zero.
- R3: A completion pulse on a channel whose count is nonzero adds a step to its address and subtracts one from its count. The step is 1 for size code 00, 2 for 01, and 4 for 10 or 11.
- R4: A channel's request output is high exactly when its enable is on, its ready input is high and its active count is nonzero.
- R5: When a move brings the count from 1 to 0 and the queued count is zero, the count stays zero and the end flag goes high on the next clock.
- R6: When a move brings the count from 1 to 0 and the queued count is nonzero, the end flag goes high, the queued address and count become active, and the queued count becomes zero. The queued address keeps its value.
- R7: A write to a channel's active count or queued count clears that channel's end flag. Address and count writes take effect for the next move.
- R8: The receive-full and transmit-empty outputs are high when both the active and the queued count of that channel are zero.
- R9: In the control word, bit 0 enables receive, bit 1 disables receive, bit 8 enables transmit and bit 9 disables transmit. A disable bit wins over an enable bit in the same write, and zero bits change nothing.
- R10: The status word shows the receive enable in bit 0 and the transmit enable in bit 8. All its other bits are zero.
- R11: Count registers keep only bits 15:0 of a write and read back with bits 31:16 as zero.
- R12: A completion pulse on a channel whose active count is zero leaves that channel's address, counts and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register window select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | 9 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_ready | input | 1 | Peripheral holds a received element |
| tx_ready | input | 1 | Peripheral can accept an element |
| rx_done | input | 1 | Sequencer finished one receive move |
| tx_done | input | 1 | Sequencer finished one transmit move |
| rx_size | input | 2 | Receive element size code |
| tx_size | input | 2 | Transmit element size code |
| rx_req | output | 1 | Receive move request |
| tx_req | output | 1 | Transmit move request |
| rx_addr | output | 32 | Current receive memory address |
| tx_addr | output | 32 | Current transmit memory address |
| rx_end | output | 1 | Receive end-of-buffer flag |
| tx_end | output | 1 | Transmit end-of-buffer flag |
| rx_full | output | 1 | Receive active and queued counts both zero |
| tx_empty | output | 1 | Transmit active and queued counts both zero |

## Verification
The step, reload and stop properties assume that no register write arrives in the same cycle as a completion pulse. They only check cycles in which no write is present. The bench keeps to this by issuing writes and completion pulses in separate clock periods, each started on a falling edge. The properties also assume that the size code is stable during the pulse cycle, and the bench holds it for the whole pulse. The completion input is not assumed to follow a request: the bench pulses a channel with a zero count on purpose to exercise the ignore case.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int OFS_BASE    = 'h100;
  localparam int OFS_DIR     = 'h8;
  localparam int OFS_CNT     = 'h4;
  localparam int OFS_QUEUED  = 'h10;
  localparam int OFS_CTRL    = 'h120;
  localparam int OFS_STATUS  = 'h124;
  localparam int NUM_DIR     = 2;
  localparam int DIR_RX      = 0;
  localparam int DIR_TX      = 1;
  localparam int CTRL_STRIDE = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } elem_size_e;

  function automatic logic [2:0] size_to_step(input logic [1:0] code);
    case (elem_size_e'(code))
      SZ_BYTE: size_to_step = 3'd1;
      SZ_HALF: size_to_step = 3'd2;
      default: size_to_step = 3'd4;
    endcase
  endfunction

  function automatic int reg_offset(input int dir, input bit queued, input bit is_cnt);
    reg_offset = OFS_BASE + dir * OFS_DIR + (queued ? OFS_QUEUED : 0) + (is_cnt ? OFS_CNT : 0);
  endfunction

endpackage

// File: rtl/dcr_enable.sv
module dcr_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic set_bit,
  input  logic clr_bit,
  output logic en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (ctl_wr && clr_bit) en_q <= 1'b0;
    else if (ctl_wr && set_bit) en_q <= 1'b1;
  end
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel #(
  parameter int PTR_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ptr,
  input  logic             wr_cnt,
  input  logic             wr_nptr,
  input  logic             wr_ncnt,
  input  logic [PTR_W-1:0] wdata,
  input  logic             done,
  input  logic [1:0]       size,
  output logic [PTR_W-1:0] ptr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [PTR_W-1:0] nptr_q,
  output logic [CNT_W-1:0] ncnt_q,
  output logic             end_q,
  output logic             drained
);
  import dcr_pkg::*;

  logic move, last_move, promote;
  logic [PTR_W-1:0] step;

  always_comb begin
    move      = done && (cnt_q != '0);
    last_move = move && (cnt_q == CNT_W'(1));
    promote   = last_move && (ncnt_q != '0);
    step      = PTR_W'(size_to_step(size));
    drained   = (cnt_q == '0) && (ncnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      nptr_q <= '0;
      ncnt_q <= '0;
      end_q  <= 1'b0;
    end else begin
      if (wr_ptr)       ptr_q <= wdata;
      else if (promote) ptr_q <= nptr_q;
      else if (move)    ptr_q <= ptr_q + step;

      if (wr_cnt)       cnt_q <= wdata[CNT_W-1:0];
      else if (promote) cnt_q <= ncnt_q;
      else if (move)    cnt_q <= cnt_q - CNT_W'(1);

      if (wr_nptr) nptr_q <= wdata;

      if (wr_ncnt)      ncnt_q <= wdata[CNT_W-1:0];
      else if (promote) ncnt_q <= '0;

      if (wr_cnt || wr_ncnt) end_q <= 1'b0;
      else if (last_move)    end_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_ready,
  input  logic              tx_ready,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic [1:0]        rx_size,
  input  logic [1:0]        tx_size,
  output logic              rx_req,
  output logic              tx_req,
  output logic [PTR_W-1:0]  rx_addr,
  output logic [PTR_W-1:0]  tx_addr,
  output logic              rx_end,
  output logic              tx_end,
  output logic              rx_full,
  output logic              tx_empty
);
  import dcr_pkg::*;

  localparam int ND = NUM_DIR;

  logic             wr_en, ctl_wr;
  logic [ND-1:0]    done_v, ready_v, en_v, end_v, drained_v, req_v;
  logic [1:0]       size_v [ND];
  logic [PTR_W-1:0] ptr_w  [ND];
  logic [PTR_W-1:0] nptr_w [ND];
  logic [CNT_W-1:0] cnt_w  [ND];
  logic [CNT_W-1:0] ncnt_w [ND];

  assign wr_en  = reg_sel && reg_wr;
  assign ctl_wr = wr_en && (reg_addr == ADDR_W'(OFS_CTRL));

  assign done_v  = {tx_done, rx_done};
  assign ready_v = {tx_ready, rx_ready};
  assign size_v[DIR_RX] = rx_size;
  assign size_v[DIR_TX] = tx_size;

  for (genvar d = 0; d < ND; d++) begin : g_dir
    logic hit_ptr, hit_cnt, hit_nptr, hit_ncnt;
    assign hit_ptr  = wr_en && (reg_addr == ADDR_W'(reg_offset(d, 1'b0, 1'b0)));
    assign hit_cnt  = wr_en && (reg_addr == ADDR_W'(reg_offset(d, 1'b0, 1'b1)));
    assign hit_nptr = wr_en && (reg_addr == ADDR_W'(reg_offset(d, 1'b1, 1'b0)));
    assign hit_ncnt = wr_en && (reg_addr == ADDR_W'(reg_offset(d, 1'b1, 1'b1)));

    dcr_channel #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ptr  (hit_ptr),
      .wr_cnt  (hit_cnt),
      .wr_nptr (hit_nptr),
      .wr_ncnt (hit_ncnt),
      .wdata   (reg_wdata[PTR_W-1:0]),
      .done    (done_v[d]),
      .size    (size_v[d]),
      .ptr_q   (ptr_w[d]),
      .cnt_q   (cnt_w[d]),
      .nptr_q  (nptr_w[d]),
      .ncnt_q  (ncnt_w[d]),
      .end_q   (end_v[d]),
      .drained (drained_v[d])
    );

    dcr_enable u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (ctl_wr),
      .set_bit (reg_wdata[d*CTRL_STRIDE]),
      .clr_bit (reg_wdata[d*CTRL_STRIDE+1]),
      .en_q    (en_v[d])
    );

    assign req_v[d] = en_v[d] && ready_v[d] && (cnt_w[d] != '0);
  end

  always_comb begin
    reg_rdata = '0;
    for (int d = 0; d < ND; d++) begin
      if (reg_addr == ADDR_W'(reg_offset(d, 1'b0, 1'b0))) reg_rdata = DATA_W'(ptr_w[d]);
      if (reg_addr == ADDR_W'(reg_offset(d, 1'b0, 1'b1))) reg_rdata = DATA_W'(cnt_w[d]);
      if (reg_addr == ADDR_W'(reg_offset(d, 1'b1, 1'b0))) reg_rdata = DATA_W'(nptr_w[d]);
      if (reg_addr == ADDR_W'(reg_offset(d, 1'b1, 1'b1))) reg_rdata = DATA_W'(ncnt_w[d]);
    end
    if (reg_addr == ADDR_W'(OFS_STATUS)) begin
      reg_rdata[DIR_RX*CTRL_STRIDE] = en_v[DIR_RX];
      reg_rdata[DIR_TX*CTRL_STRIDE] = en_v[DIR_TX];
    end
  end

  // Named internal state for the bound checker
  logic [PTR_W-1:0] rx_ptr_w;
  logic [CNT_W-1:0] rx_cnt_w, rx_ncnt_w, tx_cnt_w;
  logic             rx_en_w, tx_en_w;
  assign rx_ptr_w  = ptr_w[DIR_RX];
  assign rx_cnt_w  = cnt_w[DIR_RX];
  assign rx_ncnt_w = ncnt_w[DIR_RX];
  assign tx_cnt_w  = cnt_w[DIR_TX];
  assign rx_en_w   = en_v[DIR_RX];
  assign tx_en_w   = en_v[DIR_TX];

  assign rx_req   = req_v[DIR_RX];
  assign tx_req   = req_v[DIR_TX];
  assign rx_addr  = ptr_w[DIR_RX];
  assign tx_addr  = ptr_w[DIR_TX];
  assign rx_end   = end_v[DIR_RX];
  assign tx_end   = end_v[DIR_TX];
  assign rx_full  = drained_v[DIR_RX];
  assign tx_empty = drained_v[DIR_TX];
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rx_done,
  input logic [1:0]        rx_size,
  input logic              rx_ready,
  input logic              tx_ready,
  input logic              rx_req,
  input logic              tx_req,
  input logic              rx_end,
  input logic              rx_full,
  input logic [PTR_W-1:0]  rx_ptr,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  rx_ncnt,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic              rx_en,
  input logic              tx_en
);
  logic any_wr;
  assign any_wr = reg_sel && reg_wr;

  assert_req_gate_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_en && rx_ready && rx_cnt != '0));

  assert_req_gate_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_en && tx_ready && tx_cnt != '0));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_cnt > CNT_W'(1) && !any_wr) |=>
      (rx_ptr == $past(rx_ptr) + (($past(rx_size) == 2'b00) ? PTR_W'(1) :
                                  ($past(rx_size) == 2'b01) ? PTR_W'(2) : PTR_W'(4)))
      && (rx_cnt == $past(rx_cnt) - CNT_W'(1)));

  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_cnt == CNT_W'(1) && rx_ncnt == '0 && !any_wr) |=>
      (rx_cnt == '0 && rx_end && rx_full));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_cnt == CNT_W'(1) && rx_ncnt != '0 && !any_wr) |=>
      (rx_cnt == $past(rx_ncnt) && rx_ncnt == '0 && rx_end));

  assert_end_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && (reg_addr == ADDR_W'('h104) || reg_addr == ADDR_W'('h114))) |=> !rx_end);

  assert_disable_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && reg_addr == ADDR_W'('h120) && reg_wdata[9]) |=> !tx_en);

  assert_idle_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_cnt == '0 && !any_wr) |=> ($stable(rx_ptr) && rx_cnt == '0));
endmodule

bind dma_chan_regs dcr_checker #(
  .PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rx_done   (rx_done),
  .rx_size   (rx_size),
  .rx_ready  (rx_ready),
  .tx_ready  (tx_ready),
  .rx_req    (rx_req),
  .tx_req    (tx_req),
  .rx_end    (rx_end),
  .rx_full   (rx_full),
  .rx_ptr    (rx_ptr_w),
  .rx_cnt    (rx_cnt_w),
  .rx_ncnt   (rx_ncnt_w),
  .tx_cnt    (tx_cnt_w),
  .rx_en     (rx_en_w),
  .tx_en     (tx_en_w)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_DRX = 2'd2, K_DTX = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{K_WR,  9'h100, 32'h0000_1000, 2'd0, 8'd2},   // R2
    '{K_WR,  9'h104, 32'h0000_0003, 2'd0, 8'd2},   // R2
    '{K_WR,  9'h120, 32'h0000_0001, 2'd0, 8'd9},   // R9 rx on
    '{K_RD,  9'h124, 32'h0000_0001, 2'd0, 8'd10},  // R10
    '{K_DRX, 9'h000, 32'h0,         2'd2, 8'd3},   // R3 word
    '{K_RD,  9'h100, 32'h0000_1004, 2'd0, 8'd3},   // R3
    '{K_RD,  9'h104, 32'h0000_0002, 2'd0, 8'd3},   // R3
    '{K_DRX, 9'h000, 32'h0,         2'd0, 8'd3},   // R3 byte
    '{K_RD,  9'h100, 32'h0000_1005, 2'd0, 8'd3},   // R3
    '{K_WR,  9'h110, 32'h0000_2000, 2'd0, 8'd2},   // R2
    '{K_WR,  9'h114, 32'h0000_0005, 2'd0, 8'd2},   // R2
    '{K_DRX, 9'h000, 32'h0,         2'd1, 8'd6},   // R6 last move, promote
    '{K_RD,  9'h100, 32'h0000_2000, 2'd0, 8'd6},   // R6
    '{K_RD,  9'h104, 32'h0000_0005, 2'd0, 8'd6},   // R6
    '{K_RD,  9'h114, 32'h0000_0000, 2'd0, 8'd6},   // R6
    '{K_RD,  9'h110, 32'h0000_2000, 2'd0, 8'd6},   // R6
    '{K_WR,  9'h108, 32'h0000_3000, 2'd0, 8'd2},   // R2
    '{K_WR,  9'h10C, 32'hABCD_0002, 2'd0, 8'd11},  // R11
    '{K_RD,  9'h10C, 32'h0000_0002, 2'd0, 8'd11},  // R11
    '{K_WR,  9'h120, 32'h0000_0300, 2'd0, 8'd9},   // R9 tx on+off
    '{K_RD,  9'h124, 32'h0000_0001, 2'd0, 8'd9},   // R9
    '{K_WR,  9'h120, 32'h0000_0100, 2'd0, 8'd9},   // R9 tx on
    '{K_RD,  9'h124, 32'h0000_0101, 2'd0, 8'd10},  // R10
    '{K_DTX, 9'h000, 32'h0,         2'd3, 8'd3},   // R3 code 11
    '{K_RD,  9'h108, 32'h0000_3004, 2'd0, 8'd3},   // R3
    '{K_RD,  9'h10C, 32'h0000_0001, 2'd0, 8'd3},   // R3
    '{K_WR,  9'h120, 32'h0000_0003, 2'd0, 8'd9},   // R9 rx on+off
    '{K_RD,  9'h124, 32'h0000_0100, 2'd0, 8'd9},   // R9
    '{K_WR,  9'h120, 32'h0000_0000, 2'd0, 8'd9},   // R9 zeros
    '{K_RD,  9'h124, 32'h0000_0100, 2'd0, 8'd9},   // R9
    '{K_RD,  9'h118, 32'h0000_0000, 2'd0, 8'd2},   // R2
    '{K_WR,  9'h11C, 32'h0000_0007, 2'd0, 8'd2},   // R2
    '{K_RD,  9'h11C, 32'h0000_0007, 2'd0, 8'd2}    // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rx_ready = 0, tx_ready = 0, rx_done = 0, tx_done = 0;
  logic [1:0] rx_size = '0, tx_size = '0;
  logic rx_req, tx_req, rx_end, tx_end, rx_full, tx_empty;
  logic [31:0] rx_addr, tx_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .rx_done(rx_done), .tx_done(tx_done),
    .rx_size(rx_size), .tx_size(tx_size), .rx_req(rx_req), .tx_req(tx_req),
    .rx_addr(rx_addr), .tx_addr(tx_addr), .rx_end(rx_end), .tx_end(tx_end),
    .rx_full(rx_full), .tx_empty(tx_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2; d = reg_rdata;
  endtask

  task automatic pulse(input bit tx, input logic [1:0] sz);
    @(negedge clk);
    if (tx) begin tx_done = 1; tx_size = sz; end
    else begin rx_done = 1; rx_size = sz; end
    @(negedge clk); rx_done = 0; tx_done = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      do_read(9'(9'h100 + 4 * i), rd);
      check("R1 reset read", rd, 32'h0);
    end
    check("R1 rx_full", {31'b0, rx_full}, 32'h1);
    check("R1 tx_empty", {31'b0, tx_empty}, 32'h1);
    check("R1 end flags", {30'b0, tx_end, rx_end}, 32'h0);
    check("R1 requests", {30'b0, tx_req, rx_req}, 32'h0);
    do_read(9'h128, rd); check("R2 unmapped offset", rd, 32'h0);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].kind)
        K_WR:  do_write(VECS[v].addr, VECS[v].data);
        K_DRX: pulse(1'b0, VECS[v].size);
        K_DTX: pulse(1'b1, VECS[v].size);
        default: begin
          do_read(VECS[v].addr, rd);
          check($sformatf("R%0d vector %0d", VECS[v].tag, v), rd, VECS[v].data);
        end
      endcase
    end

    do_read(9'h120, rd); check("R2 control reads zero", rd, 32'h0);
    check("R6 end after promote", {31'b0, rx_end}, 32'h1);
    check("R8 rx_full low with count", {31'b0, rx_full}, 32'h0);
    do_write(9'h104, 32'h1);
    check("R7 count write clears end", {31'b0, rx_end}, 32'h0);
    pulse(1'b0, 2'd2);
    check("R5 end on stop", {31'b0, rx_end}, 32'h1);
    check("R8 rx_full when drained", {31'b0, rx_full}, 32'h1);
    do_read(9'h100, rd); check("R3 addr after stop", rd, 32'h2004);
    pulse(1'b0, 2'd2);
    do_read(9'h100, rd); check("R12 idle pulse addr", rd, 32'h2004);
    do_read(9'h104, rd); check("R12 idle pulse count", rd, 32'h0);
    check("R12 end kept", {31'b0, rx_end}, 32'h1);

    do_write(9'h120, 32'h1);
    @(negedge clk); rx_ready = 1; #2;
    check("R4 zero count blocks", {31'b0, rx_req}, 32'h0);
    do_write(9'h104, 32'h2); #2;
    check("R4 request raised", {31'b0, rx_req}, 32'h1);
    @(negedge clk); rx_ready = 0; #2;
    check("R4 not ready", {31'b0, rx_req}, 32'h0);

    pulse(1'b1, 2'd0);
    check("R6 tx end on promote", {31'b0, tx_end}, 32'h1);
    do_read(9'h108, rd); check("R6 tx addr from queue", rd, 32'h0);
    do_read(9'h10C, rd); check("R6 tx count from queue", rd, 32'h7);
    check("R8 tx_empty low", {31'b0, tx_empty}, 32'h0);
    do_write(9'h11C, 32'h4);
    check("R7 queued write clears end", {31'b0, tx_end}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule